// File: doc/BRIEF.md
# Even/Odd Dual-Issue Pairing Logic

This block is the issue stage of an in-order core that has two unequal execution pipes. The even pipe runs only fixed-point and floating-point arithmetic. The odd pipe runs memory access, logic and flow control, which includes branches and branch hints. Each pipe also has its own no-op. Every cycle the block looks at the two oldest fetched instruction words. For each word it sees a valid bit, a word address, a two-bit pipe class and an external ready flag that stands in for operand dependency checking. From these it decides how many of the two words leave the fetch queue: none, the head alone, or both together.

Each word that issues is steered to its pipe. A pipe register then presents that word's address and a no-op flag for one cycle. A pair issues only under three conditions: the head sits at an even word address, the head belongs to the even pipe, and the word after it belongs to the odd pipe and is the sequentially next word. If any condition fails, the head issues alone and the younger word becomes the head in the next cycle. A stall blocks all issue. The fetch queue keeps its contents during a stall because the block reports a take count of zero.

Top module: `dual_issue_pairer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `even_vld` and `odd_vld` are 0.
- R2: `take_cnt` is 2 only when bit 0 of `head_addr` is 0 (even word address).
- R3: `take_cnt` is 2 only when the head class is an even-pipe class (code 0 arithmetic or code 1 even no-op) and the next class is an odd-pipe class (code 2 odd operation or code 3 odd no-op). Class bit 1 selects the pipe: 0 means even, 1 means odd.
- R4: `take_cnt` is 2 only when both words are valid and ready and `next_addr` equals `head_addr + 1`.
- R5: If the head is valid and ready, no stall is present, and any pairing condition fails, then `take_cnt` is 1. Only the head issues.
- R6: If the head is not valid or not ready, `take_cnt` is 0, whatever the state of the next word.
- R7: While `stall` is 1, `take_cnt` is 0, and in the following cycle both pipe valids are 0.
- R8: One cycle after a decision, each pipe register holds the address of the word steered to that pipe, with valid 1. The head goes to the pipe named by its class bit 1. The second word of a pair goes to the odd pipe. A pipe with no word steered to it shows valid 0. No pipe ever receives two words in the same cycle.
- R9: The no-op flag of a pipe register is 1 exactly when the steered word has class code 1 (even pipe) or class code 3 (odd pipe).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Blocks all issue this cycle |
| head_vld | input | 1 | Oldest fetched word present |
| head_addr | input | AW | Word address of the oldest word |
| head_cls | input | 2 | Pipe class of the oldest word |
| head_rdy | input | 1 | Oldest word's operands ready |
| next_vld | input | 1 | Second word present |
| next_addr | input | AW | Word address of the second word |
| next_cls | input | 2 | Pipe class of the second word |
| next_rdy | input | 1 | Second word's operands ready |
| take_cnt | output | 2 | Words consumed this cycle (0, 1 or 2) |
| even_vld | output | 1 | Even pipe receives a word |
| even_addr | output | AW | Address of the even-pipe word |
| even_nop | output | 1 | Even-pipe word is a no-op |
| odd_vld | output | 1 | Odd pipe receives a word |
| odd_addr | output | AW | Address of the odd-pipe word |
| odd_nop | output | 1 | Odd-pipe word is a no-op |

## Verification
The pairing decision is combinational, so a wrong decision shows up in `take_cnt` in the same cycle. If the decision wrongly splits a legal pair, the take count drops from 2 to 1. If it wrongly joins two words, the odd pipe picks up a second word that should have waited. A wrong steering or no-op selection shows up at the pipe registers one edge later, as a wrong valid, address or flag. Each stimulus is therefore checked twice: once before the edge on the take count, and once after it on the pipe outputs.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [1:0] {
    CLS_EARITH = 2'd0,
    CLS_ENOP   = 2'd1,
    CLS_OOP    = 2'd2,
    CLS_ONOP   = 2'd3
  } icls_e;

  localparam int PIPES = 2;

  function automatic logic cls_pipe(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic cls_nop(input logic [1:0] c);
    return c[0];
  endfunction
endpackage

// File: rtl/pair_decide.sv
module pair_decide #(
  parameter int AW = 16
) (
  input  logic          stall,
  input  logic          head_vld,
  input  logic [AW-1:0] head_addr,
  input  logic [1:0]    head_cls,
  input  logic          head_rdy,
  input  logic          next_vld,
  input  logic [AW-1:0] next_addr,
  input  logic [1:0]    next_cls,
  input  logic          next_rdy,
  output logic          head_go,
  output logic          pair_go,
  output logic          head_pipe,
  output logic [1:0]    take_cnt
);
  import dip_pkg::*;

  logic aligned, order_ok, adjacent, next_ok;

  always_comb begin
    head_go   = head_vld & head_rdy & ~stall;
    head_pipe = cls_pipe(head_cls);
    aligned   = ~head_addr[0];
    order_ok  = ~cls_pipe(head_cls) & cls_pipe(next_cls);
    adjacent  = (next_addr == AW'(head_addr + 1'b1));
    next_ok   = next_vld & next_rdy;
    pair_go   = head_go & next_ok & aligned & order_ok & adjacent;
    take_cnt  = pair_go ? 2'd2 : (head_go ? 2'd1 : 2'd0);
  end
endmodule

// File: rtl/pipe_slot.sv
module pipe_slot #(
  parameter int   AW   = 16,
  parameter logic PIPE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_go,
  input  logic          head_pipe,
  input  logic [AW-1:0] head_addr,
  input  logic [1:0]    head_cls,
  input  logic          pair_go,
  input  logic [AW-1:0] next_addr,
  input  logic [1:0]    next_cls,
  output logic          vld,
  output logic [AW-1:0] addr,
  output logic          nop
);
  import dip_pkg::*;

  logic          take_head, take_next;
  logic [AW-1:0] addr_d;
  logic          nop_d;

  always_comb begin
    take_head = head_go & (head_pipe == PIPE);
    take_next = pair_go & (PIPE == 1'b1);
    addr_d    = take_next ? next_addr : head_addr;
    nop_d     = take_next ? cls_nop(next_cls) : cls_nop(head_cls);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      addr <= '0;
      nop  <= 1'b0;
    end else begin
      vld <= take_head | take_next;
      if (take_head | take_next) begin
        addr <= addr_d;
        nop  <= nop_d;
      end
    end
  end
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          head_vld,
  input  logic [AW-1:0] head_addr,
  input  logic [1:0]    head_cls,
  input  logic          head_rdy,
  input  logic          next_vld,
  input  logic [AW-1:0] next_addr,
  input  logic [1:0]    next_cls,
  input  logic          next_rdy,
  output logic [1:0]    take_cnt,
  output logic          even_vld,
  output logic [AW-1:0] even_addr,
  output logic          even_nop,
  output logic          odd_vld,
  output logic [AW-1:0] odd_addr,
  output logic          odd_nop
);
  import dip_pkg::*;

  logic head_go, pair_go, head_pipe;
  logic [PIPES-1:0] slot_vld, slot_nop;
  logic [AW-1:0]    slot_addr [PIPES];

  pair_decide #(.AW(AW)) u_decide (
    .stall(stall), .head_vld(head_vld), .head_addr(head_addr),
    .head_cls(head_cls), .head_rdy(head_rdy), .next_vld(next_vld),
    .next_addr(next_addr), .next_cls(next_cls), .next_rdy(next_rdy),
    .head_go(head_go), .pair_go(pair_go), .head_pipe(head_pipe),
    .take_cnt(take_cnt)
  );

  for (genvar p = 0; p < PIPES; p++) begin : g_pipe
    pipe_slot #(.AW(AW), .PIPE(p[0])) u_slot (
      .clk(clk), .rst_n(rst_n), .head_go(head_go), .head_pipe(head_pipe),
      .head_addr(head_addr), .head_cls(head_cls), .pair_go(pair_go),
      .next_addr(next_addr), .next_cls(next_cls),
      .vld(slot_vld[p]), .addr(slot_addr[p]), .nop(slot_nop[p])
    );
  end

  assign even_vld  = slot_vld[0];
  assign even_addr = slot_addr[0];
  assign even_nop  = slot_nop[0];
  assign odd_vld   = slot_vld[1];
  assign odd_addr  = slot_addr[1];
  assign odd_nop   = slot_nop[1];
endmodule

// File: rtl/pair_checker.sv
module pair_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          head_vld,
  input logic          head_rdy,
  input logic [AW-1:0] head_addr,
  input logic [1:0]    head_cls,
  input logic [AW-1:0] next_addr,
  input logic [1:0]    next_cls,
  input logic          head_go,
  input logic          pair_go,
  input logic          head_pipe,
  input logic [1:0]    take_cnt,
  input logic          even_vld,
  input logic [AW-1:0] even_addr,
  input logic          odd_vld,
  input logic [AW-1:0] odd_addr
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!even_vld && !odd_vld));

  a_r2_pair_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cnt == 2'd2) |-> !head_addr[0]);

  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cnt == 2'd2) |-> (!head_cls[1] && next_cls[1]));

  a_r4_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cnt == 2'd2) |-> (next_addr == AW'(head_addr + 1'b1)));

  a_r6_head_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_vld || !head_rdy) |-> (take_cnt == 2'd0));

  a_r7_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!even_vld && !odd_vld));

  a_r8_even_route: assert property (@(posedge clk) disable iff (!rst_n)
    (head_go && !head_pipe) |=> (even_vld && even_addr == $past(head_addr)));

  a_r8_odd_route: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |=> (odd_vld && odd_addr == $past(next_addr)));

  a_r8_one_per_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |-> (head_go && !head_pipe));
endmodule

bind dual_issue_pairer pair_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .head_vld(head_vld),
  .head_rdy(head_rdy), .head_addr(head_addr), .head_cls(head_cls),
  .next_addr(next_addr), .next_cls(next_cls), .head_go(head_go),
  .pair_go(pair_go), .head_pipe(head_pipe), .take_cnt(take_cnt),
  .even_vld(even_vld), .even_addr(even_addr), .odd_vld(odd_vld),
  .odd_addr(odd_addr)
);

// File: tb/test_dual_issue_pairer.sv
module test_dual_issue_pairer;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic head_vld = 1'b0, head_rdy = 1'b0, next_vld = 1'b0, next_rdy = 1'b0;
  logic [AW-1:0] head_addr = '0, next_addr = '0;
  logic [1:0] head_cls = '0, next_cls = '0;
  logic [1:0] take_cnt;
  logic even_vld, even_nop, odd_vld, odd_nop;
  logic [AW-1:0] even_addr, odd_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic          x_ev, x_en, x_ov, x_on;
  logic [AW-1:0] x_ea, x_oa;

  always #10 clk = ~clk;

  dual_issue_pairer #(.AW(AW)) i_dual_issue_pairer (.*);

  function automatic logic [1:0] ref_take(
      input logic st, hv, hr, input logic [AW-1:0] ha, input logic [1:0] hc,
      input logic nv, nr, input logic [AW-1:0] na, input logic [1:0] nc);
    if (st || !hv || !hr) return 2'd0;
    if (!nv || !nr) return 2'd1;
    if (ha % 2 != 0) return 2'd1;
    if (hc >= 2 || nc < 2) return 2'd1;
    if (na - ha != 1) return 2'd1;
    return 2'd2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_regs(input string req);
    chk({req, " even_vld"}, even_vld, x_ev);
    chk({req, " odd_vld"}, odd_vld, x_ov);
    if (x_ev) begin
      chk({req, " even_addr"}, even_addr, x_ea);
      chk({"R9 ", req, " even_nop"}, even_nop, x_en);
    end
    if (x_ov) begin
      chk({req, " odd_addr"}, odd_addr, x_oa);
      chk({"R9 ", req, " odd_nop"}, odd_nop, x_on);
    end
  endtask

  task automatic step(input string req, input logic st, hv, hr,
      input logic [AW-1:0] ha, input logic [1:0] hc,
      input logic nv, nr, input logic [AW-1:0] na, input logic [1:0] nc);
    logic [1:0] t;
    stall = st; head_vld = hv; head_rdy = hr; head_addr = ha; head_cls = hc;
    next_vld = nv; next_rdy = nr; next_addr = na; next_cls = nc;
    #1;
    t = ref_take(st, hv, hr, ha, hc, nv, nr, na, nc);
    chk({req, " take"}, take_cnt, t);
    x_ev = (t != 0) && (hc < 2);
    x_ea = ha; x_en = (hc == 2'd1);
    x_ov = ((t != 0) && (hc >= 2)) || (t == 2);
    x_oa = (t == 2) ? na : ha;
    x_on = (t == 2) ? (nc == 2'd3) : (hc == 2'd3);
    @(negedge clk);
    check_regs({"R8 ", req});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 even_vld in reset", even_vld, 1'b0);
    chk("R1 odd_vld in reset", odd_vld, 1'b0);
    rst_n = 1'b1;
    #1;
    chk("R1 even_vld after reset", even_vld, 1'b0);
    chk("R1 odd_vld after reset", odd_vld, 1'b0);
    @(negedge clk);
    step("R4 legal pair", 0, 1, 1, 16'h0004, 2'd0, 1, 1, 16'h0005, 2'd2);
    step("R2 head at odd address", 0, 1, 1, 16'h0005, 2'd0, 1, 1, 16'h0006, 2'd2);
    step("R3 odd then even order", 0, 1, 1, 16'h0008, 2'd2, 1, 1, 16'h0009, 2'd0);
    step("R3 even then even", 0, 1, 1, 16'h000A, 2'd0, 1, 1, 16'h000B, 2'd1);
    step("R5 next not ready", 0, 1, 1, 16'h000C, 2'd0, 1, 0, 16'h000D, 2'd2);
    step("R4 next not adjacent", 0, 1, 1, 16'h0010, 2'd0, 1, 1, 16'h0020, 2'd2);
    step("R6 head not ready", 0, 1, 0, 16'h0012, 2'd0, 1, 1, 16'h0013, 2'd2);
    step("R6 head invalid", 0, 0, 1, 16'h0014, 2'd2, 1, 1, 16'h0015, 2'd2);
    step("R7 stall on legal pair", 1, 1, 1, 16'h0016, 2'd0, 1, 1, 16'h0017, 2'd2);
    step("R9 no-op pair", 0, 1, 1, 16'h0018, 2'd1, 1, 1, 16'h0019, 2'd3);
    step("R8 odd head alone", 0, 1, 1, 16'h001B, 2'd3, 1, 1, 16'h001C, 2'd2);
    step("R4 wrap pair", 0, 1, 1, 16'hFFFE, 2'd0, 1, 1, 16'hFFFF, 2'd2);
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      step("R5 random", ($urandom % 8) == 0, ($urandom % 6) != 0,
           ($urandom % 5) != 0, a, 2'($urandom), ($urandom % 6) != 0,
           ($urandom % 5) != 0, (($urandom % 5) != 0) ? AW'(a + 1) : AW'($urandom),
           2'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule